// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

This is a memory-mapped timer built from two 16-bit halves. In its joined configuration the halves form a single 32-bit down-counter. A rising enable bit loads the counter, and each time the counter runs out the block raises a timeout status bit. A one-shot mode stops the counter after that first timeout. A periodic mode reloads the counter and keeps counting. An optional single-cycle pulse can start an ADC conversion on every timeout.

A second configuration turns the joined counter into a real-time counter. The counter starts at zero and advances once per slow tick. A parameterised divider on the system clock produces that tick. When the count equals a 32-bit match value, the block raises a status bit. In a split configuration only the upper half is used, as a 16-bit down-counter with its own enable and mode bit.

Software reaches the block over a plain register bus: byte address, write enable, write data and a combinational read. A maskable level interrupt reports status, and status bits are acknowledged by writing ones to a clear register.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, every readable register returns 0, `irq` is low and `adcTrig` is low.
- R2: Configuration register (0x00) value 0 selects the joined down-counter. When control bit 0 (0x0C) goes from 0 to 1, the counter loads {high half, low half} = N. Raw status bit 0 (0x1C) becomes set N+1 cycles after the write edge. In periodic mode (mode A register 0x04, bit 0 = 0) the block then times out every N+1 cycles.
- R3: With mode A bit 0 = 1, the joined counter times out exactly once and then stays stopped until control bit 0 is cleared and set again.
- R4: In configuration 0 with control bit 5 set, `adcTrig` is high for one cycle, in the same cycle that a timeout sets status bit 0. It is never high otherwise.
- R5: Configuration value 1 selects the real-time counter. It starts at 0 when enabled and advances by one every TICK_DIV cycles. Status bit 1 is set when the count reaches {match high, match low} (0x30/0x34), which happens TICK_DIV·M cycles after the enable write edge for a match value M ≥ 1.
- R6: The mask register (0x18) keeps only bits 6:4 and 2:0. The masked status (0x20) reads raw AND mask, and `irq` is high exactly when that value is non-zero.
- R7: Writing ones to the clear register (0x24) clears those raw status bits at that edge. A status event in that same cycle wins, and its bit stays set.
- R8: A write to 0x28 (0x30) stores bits 15:0 in the low load (match) half. When the configuration is below 4, it also stores bits 31:16 in the high half, and the read of 0x28 (0x30) returns both halves. From configuration 4 upward, only the low half is written and read. A write to 0x2C (0x34) stores bits 15:0 in the high half, and reads of 0x2C (0x34) return it.
- R9: The four prescale registers at 0x38, 0x3C, 0x40 and 0x44 read back the full 32 bits last written.
- R10: Control bit 8 starts the high half only when the configuration is 4 or more. The high half then counts down from its load value H, sets status bit 4 H+1 cycles after the write edge, and follows mode B bit 0 (0x08) for one-shot or periodic. Below configuration 4, bit 8 leaves status bit 4 at 0.
- R11: Clearing control bit 0 stops the joined counter. No further timeouts or trigger pulses follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 2*HALF_W | Write data |
| busRdata | output | 2*HALF_W | Combinational read data for `busAddr` |
| irq | output | 1 | Level interrupt, high while masked status is non-zero |
| adcTrig | output | 1 | One-cycle conversion-start pulse |

## Verification
The hardest case to reach is the collision in R7, where a clear write lands on the same edge as a fresh timeout. Only that exact alignment shows whether the event wins over the acknowledge. The stimulus forces the collision by running the joined counter periodically with a load value of 0, so it times out on every cycle. It then writes the clear and reads raw status before the next edge. The reload value and the real-time match value are each swept over a range, and every mask value from 0 to 127 is applied against known raw status.

// File: rtl/dht_pkg.sv
package dht_pkg;

  localparam int STAT_W = 7;

  // register byte offsets
  localparam int OFS_CFG     = 'h00;
  localparam int OFS_MODE_A  = 'h04;
  localparam int OFS_MODE_B  = 'h08;
  localparam int OFS_CTRL    = 'h0C;
  localparam int OFS_MASK    = 'h18;
  localparam int OFS_RAW     = 'h1C;
  localparam int OFS_MSK_ST  = 'h20;
  localparam int OFS_CLEAR   = 'h24;
  localparam int OFS_LOAD_A  = 'h28;
  localparam int OFS_LOAD_B  = 'h2C;
  localparam int OFS_MATCH_A = 'h30;
  localparam int OFS_MATCH_B = 'h34;
  localparam int OFS_PRE0    = 'h38;
  localparam int NUM_PRE     = 4;

  // control bit positions
  localparam int CTL_EN_A = 0;
  localparam int CTL_TRIG = 5;
  localparam int CTL_EN_B = 8;
  localparam int CTL_W    = 9;

  // status bit positions
  localparam int ST_TO_A = 0;
  localparam int ST_RTC  = 1;
  localparam int ST_TO_B = 4;
  localparam logic [STAT_W-1:0] MASK_KEEP = 7'h77;

  typedef struct packed {
    logic              startA;
    logic              stopA;
    logic              startB;
    logic              stopB;
    logic [STAT_W-1:0] clrBits;
  } dhtStrobe_t;

endpackage

// File: rtl/dht_regs.sv
module dht_regs
  import dht_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16,
  parameter int CFG_W  = 3,
  parameter int MODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [2*HALF_W-1:0]   busWdata,
  output logic [2*HALF_W-1:0]   busRdata,
  input  logic [STAT_W-1:0]     rawStat,
  output dhtStrobe_t            strobes,
  output logic [CFG_W-1:0]      cfg,
  output logic                  oneShotA,
  output logic                  oneShotB,
  output logic                  trigEn,
  output logic [HALF_W-1:0]     loadLo,
  output logic [HALF_W-1:0]     loadHi,
  output logic [HALF_W-1:0]     matchLo,
  output logic [HALF_W-1:0]     matchHi,
  output logic [STAT_W-1:0]     maskBits
);

  localparam int DATA_W = 2 * HALF_W;
  localparam logic [CTL_W-1:0] CTL_KEEP =
    CTL_W'((1 << CTL_EN_A) | (1 << CTL_TRIG) | (1 << CTL_EN_B));

  logic [MODE_W-1:0] modeA, modeB;
  logic [CTL_W-1:0]  ctrlReg;
  logic [DATA_W-1:0] preReg [NUM_PRE];
  logic              split;
  logic              wrCtrl;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign split  = cfg >= CFG_W'(4);
  assign wrCtrl = busWe && hit(busAddr, OFS_CTRL);

  // strobes towards the counting datapath
  always_comb begin
    strobes.startA  = wrCtrl && busWdata[CTL_EN_A] && !ctrlReg[CTL_EN_A];
    strobes.stopA   = wrCtrl && !busWdata[CTL_EN_A] && ctrlReg[CTL_EN_A];
    strobes.startB  = wrCtrl && busWdata[CTL_EN_B] && !ctrlReg[CTL_EN_B] && split;
    strobes.stopB   = wrCtrl && !busWdata[CTL_EN_B] && ctrlReg[CTL_EN_B];
    strobes.clrBits = (busWe && hit(busAddr, OFS_CLEAR)) ? busWdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      modeA    <= '0;
      modeB    <= '0;
      ctrlReg  <= '0;
      maskBits <= '0;
      loadLo   <= '0;
      loadHi   <= '0;
      matchLo  <= '0;
      matchHi  <= '0;
    end else if (busWe) begin
      if (hit(busAddr, OFS_CFG))    cfg      <= busWdata[CFG_W-1:0];
      if (hit(busAddr, OFS_MODE_A)) modeA    <= busWdata[MODE_W-1:0];
      if (hit(busAddr, OFS_MODE_B)) modeB    <= busWdata[MODE_W-1:0];
      if (wrCtrl)                   ctrlReg  <= busWdata[CTL_W-1:0] & CTL_KEEP;
      if (hit(busAddr, OFS_MASK))   maskBits <= busWdata[STAT_W-1:0] & MASK_KEEP;
      if (hit(busAddr, OFS_LOAD_A)) begin
        loadLo <= busWdata[HALF_W-1:0];
        if (!split) loadHi <= busWdata[DATA_W-1:HALF_W];
      end
      if (hit(busAddr, OFS_LOAD_B)) loadHi <= busWdata[HALF_W-1:0];
      if (hit(busAddr, OFS_MATCH_A)) begin
        matchLo <= busWdata[HALF_W-1:0];
        if (!split) matchHi <= busWdata[DATA_W-1:HALF_W];
      end
      if (hit(busAddr, OFS_MATCH_B)) matchHi <= busWdata[HALF_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_PRE; i++) begin : g_pre
    always_ff @(posedge clk) begin
      if (!rstN)
        preReg[i] <= '0;
      else if (busWe && hit(busAddr, OFS_PRE0 + 4 * i))
        preReg[i] <= busWdata;
    end
  end

  assign oneShotA = modeA[0];
  assign oneShotB = modeB[0];
  assign trigEn   = ctrlReg[CTL_TRIG];

  always_comb begin
    busRdata = '0;
    if (hit(busAddr, OFS_CFG))     busRdata = DATA_W'(cfg);
    if (hit(busAddr, OFS_MODE_A))  busRdata = DATA_W'(modeA);
    if (hit(busAddr, OFS_MODE_B))  busRdata = DATA_W'(modeB);
    if (hit(busAddr, OFS_CTRL))    busRdata = DATA_W'(ctrlReg);
    if (hit(busAddr, OFS_MASK))    busRdata = DATA_W'(maskBits);
    if (hit(busAddr, OFS_RAW))     busRdata = DATA_W'(rawStat);
    if (hit(busAddr, OFS_MSK_ST))  busRdata = DATA_W'(rawStat & maskBits);
    if (hit(busAddr, OFS_LOAD_A))  busRdata = {split ? HALF_W'(0) : loadHi, loadLo};
    if (hit(busAddr, OFS_LOAD_B))  busRdata = DATA_W'(loadHi);
    if (hit(busAddr, OFS_MATCH_A)) busRdata = {split ? HALF_W'(0) : matchHi, matchLo};
    if (hit(busAddr, OFS_MATCH_B)) busRdata = DATA_W'(matchHi);
    for (int i = 0; i < NUM_PRE; i++)
      if (hit(busAddr, OFS_PRE0 + 4 * i)) busRdata = preReg[i];
  end

  // R10
  split_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startB |=> ctrlReg[CTL_EN_B] && cfg >= CFG_W'(4));

endmodule

// File: rtl/dht_core.sv
module dht_core
  import dht_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int CFG_W    = 3,
  parameter int TICK_DIV = 50_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  dhtStrobe_t          strobes,
  input  logic [CFG_W-1:0]    cfg,
  input  logic                oneShotA,
  input  logic                oneShotB,
  input  logic                trigEn,
  input  logic [HALF_W-1:0]   loadLo,
  input  logic [HALF_W-1:0]   loadHi,
  input  logic [HALF_W-1:0]   matchLo,
  input  logic [HALF_W-1:0]   matchHi,
  input  logic [STAT_W-1:0]   maskBits,
  output logic [STAT_W-1:0]   rawStat,
  output logic                irq,
  output logic                adcTrig
);

  localparam int FULL_W = 2 * HALF_W;
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [FULL_W-1:0] reload, matchVal, cntA;
  logic [HALF_W-1:0] cntB;
  logic [TICK_W-1:0] tickCnt;
  logic              runA, runB;
  logic              modeDown, modeRtc;
  logic              timeoutA, tick, rtcHit, timeoutB;
  logic [STAT_W-1:0] evtBits;

  assign reload   = {loadHi, loadLo};
  assign matchVal = {matchHi, matchLo};
  assign modeDown = cfg == CFG_W'(0);
  assign modeRtc  = cfg == CFG_W'(1);

  always_comb begin
    timeoutA = runA && modeDown && cntA == '0 && !strobes.startA && !strobes.stopA;
    tick     = runA && modeRtc && tickCnt == TICK_LAST;
    rtcHit   = tick && (cntA + 1'b1) == matchVal && !strobes.startA && !strobes.stopA;
    timeoutB = runB && cntB == '0 && !strobes.startB && !strobes.stopB;
    evtBits  = '0;
    evtBits[ST_TO_A] = timeoutA;
    evtBits[ST_RTC]  = rtcHit;
    evtBits[ST_TO_B] = timeoutB;
  end

  // joined counter: down-counter or real-time counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runA    <= 1'b0;
      cntA    <= '0;
      tickCnt <= '0;
    end else if (strobes.startA) begin
      runA    <= 1'b1;
      cntA    <= modeRtc ? '0 : reload;
      tickCnt <= '0;
    end else if (strobes.stopA) begin
      runA    <= 1'b0;
    end else if (runA) begin
      if (modeDown) begin
        if (cntA == '0) begin
          if (oneShotA) runA <= 1'b0;
          else          cntA <= reload;
        end else begin
          cntA <= cntA - 1'b1;
        end
      end else if (modeRtc) begin
        tickCnt <= tick ? '0 : tickCnt + 1'b1;
        if (tick) cntA <= cntA + 1'b1;
      end
    end
  end

  // upper half alone, split configurations
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runB <= 1'b0;
      cntB <= '0;
    end else if (strobes.startB) begin
      runB <= 1'b1;
      cntB <= loadHi;
    end else if (strobes.stopB) begin
      runB <= 1'b0;
    end else if (runB) begin
      if (cntB == '0) begin
        if (oneShotB) runB <= 1'b0;
        else          cntB <= loadHi;
      end else begin
        cntB <= cntB - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawStat <= '0;
      adcTrig <= 1'b0;
    end else begin
      rawStat <= (rawStat & ~strobes.clrBits) | evtBits;
      adcTrig <= timeoutA && trigEn;
    end
  end

  assign irq = |(rawStat & maskBits);

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutA && !oneShotA) |=> cntA == $past(reload));

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutA && oneShotA) |=> !runA);

  // R4
  trig_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |-> $past(modeDown) && $past(trigEn));

  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcTrig && $past(reload) != '0) |=> !adcTrig);

  // R5
  rtc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runA && modeRtc && !strobes.startA) |=> (cntA == $past(cntA) || cntA == $past(cntA) + 1'b1));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrBits == {STAT_W{1'b1}} && evtBits == '0) |=> rawStat == '0);

endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_W   = 16,
  parameter int TICK_DIV = 50_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [2*HALF_W-1:0] busWdata,
  output logic [2*HALF_W-1:0] busRdata,
  output logic                irq,
  output logic                adcTrig
);

  localparam int CFG_W = 3;

  dhtStrobe_t         strobes;
  logic [CFG_W-1:0]   cfg;
  logic               oneShotA, oneShotB, trigEn;
  logic [HALF_W-1:0]  loadLo, loadHi, matchLo, matchHi;
  logic [STAT_W-1:0]  maskBits, rawStat;

  dht_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .rawStat(rawStat),
    .strobes(strobes), .cfg(cfg), .oneShotA(oneShotA), .oneShotB(oneShotB),
    .trigEn(trigEn), .loadLo(loadLo), .loadHi(loadHi), .matchLo(matchLo),
    .matchHi(matchHi), .maskBits(maskBits)
  );

  dht_core #(.HALF_W(HALF_W), .CFG_W(CFG_W), .TICK_DIV(TICK_DIV)) u_core (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfg(cfg),
    .oneShotA(oneShotA), .oneShotB(oneShotB), .trigEn(trigEn),
    .loadLo(loadLo), .loadHi(loadHi), .matchLo(matchLo), .matchHi(matchHi),
    .maskBits(maskBits), .rawStat(rawStat), .irq(irq), .adcTrig(adcTrig)
  );

endmodule

// File: tb/dual_half_timer_bench.sv
module dual_half_timer_bench;

  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, adcTrig;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_half_timer #(.ADDR_W(8), .HALF_W(16), .TICK_DIV(TDIV)) u_dual_half_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .adcTrig(adcTrig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h7F);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int pulses;
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 'h48; a += 4) begin
      rd(8'(a), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 adcTrig", 32'(adcTrig), 0);

    // R2 / R4 first timeout timing, swept reload
    for (int n = 0; n < 8; n++) begin
      wr(8'h28, 32'(n));
      wr(8'h0C, 32'h21);
      cyc(n);
      rd(8'h1C, v);
      chk("R2 before timeout", v, 32'h0);
      cyc(1);
      rd(8'h1C, v);
      chk("R2 at timeout", v, 32'h1);
      chk("R4 pulse", 32'(adcTrig), 1);
      if (n > 0) begin
        cyc(1);
        chk("R4 pulse ends", 32'(adcTrig), 0);
      end
      quiesce();
      // periodic: four pulses in 4*(n+1) cycles
      wr(8'h0C, 32'h21);
      pulses = 0;
      for (int k = 0; k < 4 * (n + 1); k++) begin
        cyc(1);
        if (adcTrig) pulses++;
      end
      chk("R2 periodic count", 32'(pulses), 32'd4);
      quiesce();
    end

    // R4 no pulse with trigger bit clear
    wr(8'h28, 32'h2);
    wr(8'h0C, 32'h01);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin cyc(1); if (adcTrig) pulses++; end
    chk("R4 gated off", 32'(pulses), 0);
    rd(8'h1C, v);
    chk("R4 status still set", v, 32'h1);
    quiesce();

    // R3 one-shot
    wr(8'h04, 32'h1);
    wr(8'h28, 32'h3);
    wr(8'h0C, 32'h21);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin cyc(1); if (adcTrig) pulses++; end
    chk("R3 single timeout", 32'(pulses), 1);
    quiesce();
    wr(8'h04, 32'h0);

    // R11 stop
    wr(8'h28, 32'h2);
    wr(8'h0C, 32'h21);
    cyc(7);
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h7F);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin cyc(1); if (adcTrig) pulses++; end
    rd(8'h1C, v);
    chk("R11 no status after stop", v, 32'h0);
    chk("R11 no pulse after stop", 32'(pulses), 0);

    // R7 clear collides with a timeout: event wins
    wr(8'h28, 32'h0);
    wr(8'h0C, 32'h01);
    cyc(2);
    wr(8'h24, 32'h1);
    rd(8'h1C, v);
    chk("R7 event beats clear", v, 32'h1);
    wr(8'h0C, 32'h0);
    cyc(2);
    // raw bit0 held; plain clear of an idle bit
    rd(8'h1C, v);
    chk("R7 held", v, 32'h1);

    // R6 mask sweep with raw = 0x01
    for (int m = 0; m < 128; m++) begin
      wr(8'h18, 32'(m));
      rd(8'h18, v);
      chk("R6 mask keep", v, 32'(m & 'h77));
      rd(8'h20, v);
      chk("R6 masked status", v, 32'(m & 'h01));
      chk("R6 irq", 32'(irq), 32'((m & 1) != 0));
    end
    wr(8'h24, 32'h1);
    rd(8'h1C, v);
    chk("R7 clear", v, 32'h0);
    chk("R6 irq low after clear", 32'(irq), 0);

    // R5 real-time counter, swept match
    wr(8'h00, 32'h1);
    for (int mt = 1; mt < 5; mt++) begin
      wr(8'h30, 32'(mt));
      wr(8'h0C, 32'h21);
      cyc(TDIV * mt - 1);
      rd(8'h1C, v);
      chk("R5 before match", v, 32'h0);
      cyc(1);
      rd(8'h1C, v);
      chk("R5 at match", v, 32'h2);
      chk("R4 no pulse in rtc", 32'(adcTrig), 0);
      quiesce();
    end
    wr(8'h00, 32'h0);

    // R8 halves
    wr(8'h28, 32'hAAAA5555);
    rd(8'h28, v); chk("R8 joined load", v, 32'hAAAA5555);
    rd(8'h2C, v); chk("R8 high half", v, 32'h0000AAAA);
    wr(8'h30, 32'h13572468);
    rd(8'h30, v); chk("R8 joined match", v, 32'h13572468);
    rd(8'h34, v); chk("R8 match high", v, 32'h00001357);
    wr(8'h00, 32'h4);
    wr(8'h28, 32'h12345678);
    rd(8'h28, v); chk("R8 split load", v, 32'h00005678);
    rd(8'h2C, v); chk("R8 high kept", v, 32'h0000AAAA);
    wr(8'h30, 32'hFFFF0001);
    rd(8'h30, v); chk("R8 split match", v, 32'h00000001);
    rd(8'h34, v); chk("R8 match high kept", v, 32'h00001357);
    wr(8'h2C, 32'hFFFFBEEF);
    rd(8'h2C, v); chk("R8 write high", v, 32'h0000BEEF);

    // R10 split upper half, swept load
    for (int h = 0; h < 5; h++) begin
      wr(8'h2C, 32'(h));
      wr(8'h0C, 32'h100);
      cyc(h);
      rd(8'h1C, v); chk("R10 before timeout", v, 32'h0);
      cyc(1);
      rd(8'h1C, v); chk("R10 timeout", v, 32'h10);
      wr(8'h0C, 32'h0);
      wr(8'h24, 32'h7F);
    end
    wr(8'h08, 32'h1);
    wr(8'h2C, 32'h2);
    wr(8'h0C, 32'h100);
    cyc(4);
    wr(8'h24, 32'h10);
    cyc(10);
    rd(8'h1C, v); chk("R10 one-shot stays quiet", v, 32'h0);
    quiesce();
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'h100);
    cyc(15);
    rd(8'h1C, v); chk("R10 ignored when joined", v, 32'h0);
    quiesce();

    // R9 prescale registers
    for (int i = 0; i < 4; i++)
      wr(8'('h38 + 4 * i), 32'hC0DE0000 + 32'(i * 'h1111));
    for (int i = 0; i < 4; i++) begin
      rd(8'('h38 + 4 * i), v);
      chk("R9 prescale", v, 32'hC0DE0000 + 32'(i * 'h1111));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule